// File: doc/BRIEF.md
# Sectored Instruction TLB with Walker Refill

This block is a small, fully associative translation buffer for instruction fetch. Every entry covers an aligned group of eight consecutive virtual pages. The entry stores one upper physical page number that the whole group shares. It also stores a 3-bit low page number and a valid bit for each of the eight sectors. Three fetch ports can each present a 50-bit virtual address in any cycle. Two clock edges later, each port returns a 48-bit physical address or a miss flag.

On a miss, the port raises a walk request that carries the full 38-bit virtual page number. The external page walker later refills one entry through the fill inputs. The fill selects a free slot in round-robin order, or it overwrites an entry that already holds the same tag, address-space ID and translation kind. Each port has its own flush input, which discards that port's in-flight requests. The third port (index 2) also has a ready input that gates the delivery of its response.

Top module: `sect_itlb`

## Requirements
- R1: A synchronous reset invalidates every entry and clears every port pipeline. After the edge that ends reset, no port shows a response or a walk request.
- R2: A request sampled at one rising edge produces its response after the second rising edge that follows. The response is absent after only the first edge, and it lasts for one cycle.
- R3: A request hits when all of these hold:
  - An entry is valid.
  - The entry tag equals the virtual page number without its low 3 bits.
  - The entry's address-space ID equals `cur_asid`.
  - The sector valid bit picked by the low 3 page bits is set.
  
  The physical address is then {upper ppn, sector low ppn, 12-bit offset}.
- R4: A request whose tag and address-space ID match, but whose selected sector valid bit is clear, reports a miss.
- R5: A miss response raises `resp_miss` for that port and, in the same cycle, raises a walk request. The walk request carries the 38-bit page number, which is vaddr bits 49:12.
- R6: The table changes only in a cycle where `fill_valid` is high. Fill data offered while `fill_valid` is low leaves a later lookup still missing.
- R7: A fill with a non-zero stage code (00 means no guest stage) creates a guest entry. A guest entry hits only when `cur_stage` is non-zero. An entry filled with code 00 hits only when `cur_stage` is 00.
- R8: A fill that matches no entry goes to the slot named by a round-robin pointer. The pointer starts at slot 0 and advances by one per such fill, so the ninth distinct fill evicts the first.
- R9: A fill whose tag, address-space ID and guest kind match a valid entry overwrites that entry in place and leaves the round-robin pointer unchanged.
- R10: A port whose flush is high at an edge drops the requests it holds and the request sampled at that edge. No response or walk request from them appears.
- R11: The response of port 2 (`resp_valid[2]`, its miss flag and its address) appears only while `resp2_ready` is high. Ports 0 and 1 are not gated.
- R12: The ports translate independently and concurrently. A lookup sees the table as it stood before any fill at the same edge.
- R13: Per-port fields are packed by port index. Port p uses `req_vaddr[p*50 +: 50]`, `resp_paddr[p*48 +: 48]` and `walk_vpn[p*38 +: 38]`. Sector i of `fill_ppn_lo` is bits `[3i+2:3i]`, and its valid bit is `fill_sec_valid[i]`. `resp_paddr` and `walk_vpn` read zero while their qualifying flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | 16 | Current address-space ID used in lookups |
| cur_stage | input | 2 | Current translation kind; non-zero selects guest entries |
| req_valid | input | 3 | Per-port request valid |
| req_vaddr | input | 150 | Per-port 50-bit virtual addresses, packed by port |
| flush | input | 3 | Per-port pipeline flush |
| resp2_ready | input | 1 | Port 2 response ready |
| resp_valid | output | 3 | Per-port response valid |
| resp_miss | output | 3 | Per-port miss flag, qualified by resp_valid |
| resp_paddr | output | 144 | Per-port 48-bit physical addresses |
| walk_valid | output | 3 | Per-port page-walk request |
| walk_vpn | output | 114 | Per-port 38-bit page numbers for the walker |
| fill_valid | input | 1 | Refill strobe |
| fill_stage | input | 2 | Translation-stage code of the refill |
| fill_tag | input | 35 | Refill tag (page number without sector bits) |
| fill_asid | input | 16 | Refill address-space ID |
| fill_ppn_hi | input | 33 | Shared upper physical page number |
| fill_ppn_lo | input | 24 | Eight 3-bit low page numbers |
| fill_sec_valid | input | 8 | Eight sector valid bits |

## Verification
The timing assertions assume two things about the inputs. First, the address on `req_vaddr` is meaningful only in cycles where `req_valid` is high. Second, a flush may arrive in any cycle. The stimulus therefore always drives a full address alongside valid, and it pulses flush at random. The bench keeps the walker honest on its own: a fill never duplicates a resident tag, address-space ID and kind, except through the overwrite path, so at most one entry can ever hit. The random phase draws tags from a small pool, so lookups both hit and miss, and fills both overwrite and evict.

// File: rtl/sect_tlb_pkg.sv
package sect_tlb_pkg;

    localparam int VA_W     = 50;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int SEC_BITS = 3;
    localparam int SECTORS  = 1 << SEC_BITS;
    localparam int TAG_W    = VPN_W - SEC_BITS;
    localparam int PPN_W    = 36;
    localparam int LO_W     = SEC_BITS;
    localparam int HI_W     = PPN_W - LO_W;
    localparam int PA_W     = PPN_W + OFF_W;
    localparam int ASID_W   = 16;

    typedef struct packed {
        logic                      valid;
        logic                      guest;
        logic [TAG_W-1:0]          tag;
        logic [ASID_W-1:0]         asid;
        logic [HI_W-1:0]           hi;
        logic [SECTORS*LO_W-1:0]   lo;
        logic [SECTORS-1:0]        sv;
    } entry_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [PA_W-1:0]   paddr;
        logic [VPN_W-1:0]  vpn;
    } resp_stage_t;

    function automatic logic is_guest(input logic [1:0] code);
        return code != 2'b00;
    endfunction

    function automatic logic same_space(input entry_t e, input logic [TAG_W-1:0] tag,
                                        input logic [ASID_W-1:0] asid, input logic guest);
        return e.valid && (e.tag == tag) && (e.asid == asid) && (e.guest == guest);
    endfunction

endpackage

// File: rtl/sect_tlb_array.sv
module sect_tlb_array
    import sect_tlb_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_PORT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic                     cur_guest,
    input  logic                     fill_valid,
    input  logic                     fill_guest,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic [HI_W-1:0]          fill_hi,
    input  logic [SECTORS*LO_W-1:0]  fill_lo,
    input  logic [SECTORS-1:0]       fill_sv,
    input  logic [N_PORT*VPN_W-1:0]  lk_vpn,
    output logic [N_PORT-1:0]        lk_hit,
    output logic [N_PORT*PPN_W-1:0]  lk_ppn
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    entry_t           tbl [N_ENT];
    logic [IDX_W-1:0] rr_ptr;
    logic             ovr_hit;
    logic [IDX_W-1:0] ovr_idx;
    logic [IDX_W-1:0] wr_idx;

    // Locate an existing entry for the same page group and space.
    always_comb begin
        ovr_hit = 1'b0;
        ovr_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!ovr_hit && same_space(tbl[i], fill_tag, fill_asid, fill_guest)) begin
                ovr_hit = 1'b1;
                ovr_idx = IDX_W'(i);
            end
        end
    end

    assign wr_idx = ovr_hit ? ovr_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
            rr_ptr <= '0;
        end else if (fill_valid) begin
            tbl[wr_idx] <= '{valid: 1'b1, guest: fill_guest, tag: fill_tag, asid: fill_asid,
                             hi: fill_hi, lo: fill_lo, sv: fill_sv};
            if (!ovr_hit)
                rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_look
        logic [VPN_W-1:0]    vpn;
        logic [SEC_BITS-1:0] sec;
        logic                hit;
        logic [PPN_W-1:0]    ppn;

        assign vpn = lk_vpn[p*VPN_W +: VPN_W];
        assign sec = vpn[SEC_BITS-1:0];

        always_comb begin
            hit = 1'b0;
            ppn = '0;
            for (int i = 0; i < N_ENT; i++) begin
                if (!hit && same_space(tbl[i], vpn[VPN_W-1:SEC_BITS], cur_asid, cur_guest)
                    && tbl[i].sv[sec]) begin
                    hit = 1'b1;
                    ppn = {tbl[i].hi, tbl[i].lo[32'(sec)*LO_W +: LO_W]};
                end
            end
        end

        assign lk_hit[p]                 = hit;
        assign lk_ppn[p*PPN_W +: PPN_W]  = ppn;
    end

endmodule

// File: rtl/sect_tlb_port.sv
module sect_tlb_port
    import sect_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ready,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_hit,
    input  logic [PPN_W-1:0]  lk_ppn,
    output logic              resp_valid,
    output logic              resp_miss,
    output logic [PA_W-1:0]   resp_paddr,
    output logic              walk_valid,
    output logic [VPN_W-1:0]  walk_vpn
);
    logic            s1_valid;
    logic [VA_W-1:0] s1_vaddr;
    resp_stage_t     s2;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s1_valid <= 1'b0;
            s2.valid <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s2.valid <= s1_valid;
        end
        s1_vaddr <= req_vaddr;
        s2.hit   <= lk_hit;
        s2.paddr <= {lk_ppn, s1_vaddr[OFF_W-1:0]};
        s2.vpn   <= s1_vaddr[VA_W-1:OFF_W];
    end

    assign lk_vpn     = s1_vaddr[VA_W-1:OFF_W];
    assign resp_valid = s2.valid && ready;
    assign resp_miss  = resp_valid && !s2.hit;
    assign resp_paddr = (resp_valid && s2.hit) ? s2.paddr : '0;
    assign walk_valid = s2.valid && !s2.hit;
    assign walk_vpn   = walk_valid ? s2.vpn : '0;

endmodule

// File: rtl/sect_itlb.sv
module sect_itlb
    import sect_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_PORTS   = 3,
    parameter int READY_PORT  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ASID_W-1:0]           cur_asid,
    input  logic [1:0]                  cur_stage,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*VA_W-1:0]   req_vaddr,
    input  logic [NUM_PORTS-1:0]        flush,
    input  logic                        resp2_ready,
    output logic [NUM_PORTS-1:0]        resp_valid,
    output logic [NUM_PORTS-1:0]        resp_miss,
    output logic [NUM_PORTS*PA_W-1:0]   resp_paddr,
    output logic [NUM_PORTS-1:0]        walk_valid,
    output logic [NUM_PORTS*VPN_W-1:0]  walk_vpn,
    input  logic                        fill_valid,
    input  logic [1:0]                  fill_stage,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [ASID_W-1:0]           fill_asid,
    input  logic [HI_W-1:0]             fill_ppn_hi,
    input  logic [SECTORS*LO_W-1:0]     fill_ppn_lo,
    input  logic [SECTORS-1:0]          fill_sec_valid
);
    logic [NUM_PORTS*VPN_W-1:0] lk_vpn;
    logic [NUM_PORTS-1:0]       lk_hit;
    logic [NUM_PORTS*PPN_W-1:0] lk_ppn;

    sect_tlb_array #(.N_ENT(NUM_ENTRIES), .N_PORT(NUM_PORTS)) u_array (
        .clk        (clk),
        .rst        (rst),
        .cur_asid   (cur_asid),
        .cur_guest  (is_guest(cur_stage)),
        .fill_valid (fill_valid),
        .fill_guest (is_guest(fill_stage)),
        .fill_tag   (fill_tag),
        .fill_asid  (fill_asid),
        .fill_hi    (fill_ppn_hi),
        .fill_lo    (fill_ppn_lo),
        .fill_sv    (fill_sec_valid),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sect_tlb_port u_port (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush[p]),
            .ready      ((p == READY_PORT) ? resp2_ready : 1'b1),
            .req_valid  (req_valid[p]),
            .req_vaddr  (req_vaddr[p*VA_W +: VA_W]),
            .lk_vpn     (lk_vpn[p*VPN_W +: VPN_W]),
            .lk_hit     (lk_hit[p]),
            .lk_ppn     (lk_ppn[p*PPN_W +: PPN_W]),
            .resp_valid (resp_valid[p]),
            .resp_miss  (resp_miss[p]),
            .resp_paddr (resp_paddr[p*PA_W +: PA_W]),
            .walk_valid (walk_valid[p]),
            .walk_vpn   (walk_vpn[p*VPN_W +: VPN_W])
        );
    end

endmodule

// File: rtl/sect_itlb_chk.sv
module sect_itlb_chk
    import sect_tlb_pkg::*;
#(
    parameter int NP = 3,
    parameter int RP = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NP-1:0]        req_valid,
    input logic [NP*VA_W-1:0]   req_vaddr,
    input logic [NP-1:0]        flush,
    input logic                 resp2_ready,
    input logic [NP-1:0]        resp_valid,
    input logic [NP-1:0]        resp_miss,
    input logic [NP*PA_W-1:0]   resp_paddr,
    input logic [NP-1:0]        walk_valid,
    input logic [NP*VPN_W-1:0]  walk_vpn
);
    for (genvar p = 0; p < NP; p++) begin : g_chk
        AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (!resp_valid[p] && !walk_valid[p])); // R1

        AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
            resp_valid[p] |-> $past(req_valid[p], 2)); // R2

        AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
            (resp_valid[p] && !resp_miss[p]) |->
            resp_paddr[p*PA_W +: OFF_W] == $past(req_vaddr[p*VA_W +: OFF_W], 2)); // R3

        AST_WALK_VPN: assert property (@(posedge clk) disable iff (rst)
            walk_valid[p] |->
            walk_vpn[p*VPN_W +: VPN_W] == $past(req_vaddr[p*VA_W+OFF_W +: VPN_W], 2)); // R5

        AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
            $past(flush[p]) |-> (!resp_valid[p] && !walk_valid[p])); // R10
    end

    AST_READY_GATE: assert property (@(posedge clk) disable iff (rst)
        !resp2_ready |-> !resp_valid[RP]); // R11

endmodule

bind sect_itlb sect_itlb_chk #(.NP(NUM_PORTS), .RP(READY_PORT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .flush       (flush),
    .resp2_ready (resp2_ready),
    .resp_valid  (resp_valid),
    .resp_miss   (resp_miss),
    .resp_paddr  (resp_paddr),
    .walk_valid  (walk_valid),
    .walk_vpn    (walk_vpn)
);

// File: tb/sim_sect_itlb.sv
module sim_sect_itlb;
    import sect_tlb_pkg::*;

    localparam int NP = 3;
    localparam int NE = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ASID_W-1:0]    cur_asid = 16'h1234;
    logic [1:0]           cur_stage = 2'b00;
    logic [NP-1:0]        req_valid = '0;
    logic [NP*VA_W-1:0]   req_vaddr = '0;
    logic [NP-1:0]        flush = '0;
    logic                 resp2_ready = 1'b1;
    logic [NP-1:0]        resp_valid;
    logic [NP-1:0]        resp_miss;
    logic [NP*PA_W-1:0]   resp_paddr;
    logic [NP-1:0]        walk_valid;
    logic [NP*VPN_W-1:0]  walk_vpn;
    logic                 fill_valid = 1'b0;
    logic [1:0]           fill_stage = 2'b00;
    logic [TAG_W-1:0]     fill_tag = '0;
    logic [ASID_W-1:0]    fill_asid = '0;
    logic [HI_W-1:0]      fill_ppn_hi = '0;
    logic [23:0]          fill_ppn_lo = '0;
    logic [7:0]           fill_sec_valid = '0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    sect_itlb u0 (
        .clk(clk), .rst(rst), .cur_asid(cur_asid), .cur_stage(cur_stage),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .flush(flush),
        .resp2_ready(resp2_ready), .resp_valid(resp_valid), .resp_miss(resp_miss),
        .resp_paddr(resp_paddr), .walk_valid(walk_valid), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_stage(fill_stage), .fill_tag(fill_tag),
        .fill_asid(fill_asid), .fill_ppn_hi(fill_ppn_hi), .fill_ppn_lo(fill_ppn_lo),
        .fill_sec_valid(fill_sec_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit               mv [NE];
    bit               mg [NE];
    logic [TAG_W-1:0] mtag [NE];
    logic [15:0]      masid [NE];
    logic [HI_W-1:0]  mhi [NE];
    logic [23:0]      mlo [NE];
    logic [7:0]       msv [NE];
    int               mrr = 0;
    bit               p1v [NP];
    logic [VA_W-1:0]  p1va [NP];
    bit               p2v [NP];
    bit               p2hit [NP];
    logic [PA_W-1:0]  p2pa [NP];
    logic [VPN_W-1:0] p2vpn [NP];
    bit               started = 0;

    task automatic mlook(input logic [VA_W-1:0] va, output bit h, output logic [PPN_W-1:0] ppn);
        int s;
        s = int'(va[14:12]);
        h = 0;
        ppn = '0;
        for (int i = 0; i < NE; i++) begin
            if (!h && mv[i] && mtag[i] == va[49:15] && masid[i] == cur_asid &&
                mg[i] == (cur_stage != 2'b00) && msv[i][s]) begin
                h = 1;
                ppn = {mhi[i], mlo[i][s*3 +: 3]};
            end
        end
    endtask

    task automatic model_step();
        bit h;
        logic [PPN_W-1:0] ppn;
        int w;
        if (rst) begin
            started = 1;
            mrr = 0;
            for (int i = 0; i < NE; i++) mv[i] = 0;
            for (int p = 0; p < NP; p++) begin p1v[p] = 0; p2v[p] = 0; end
            return;
        end
        for (int p = 0; p < NP; p++) begin
            if (flush[p]) begin
                p1v[p] = 0;
                p2v[p] = 0;
            end else begin
                mlook(p1va[p], h, ppn);
                p2v[p]   = p1v[p];
                p2hit[p] = h;
                p2pa[p]  = {ppn, p1va[p][11:0]};
                p2vpn[p] = p1va[p][49:12];
                p1v[p]   = req_valid[p];
            end
            p1va[p] = req_vaddr[p*VA_W +: VA_W];
        end
        if (fill_valid) begin
            w = -1;
            for (int i = 0; i < NE; i++)
                if (w < 0 && mv[i] && mtag[i] == fill_tag && masid[i] == fill_asid &&
                    mg[i] == (fill_stage != 2'b00)) w = i;
            if (w < 0) begin
                w = mrr;
                mrr = (mrr + 1) % NE;
            end
            mv[w] = 1; mg[w] = (fill_stage != 2'b00); mtag[w] = fill_tag;
            masid[w] = fill_asid; mhi[w] = fill_ppn_hi; mlo[w] = fill_ppn_lo;
            msv[w] = fill_sec_valid;
        end
    endtask

    task automatic model_compare();
        bit erv, emiss, ewv;
        logic [PA_W-1:0] epa;
        logic [VPN_W-1:0] evpn;
        for (int p = 0; p < NP; p++) begin
            erv   = p2v[p] && (p != 2 || resp2_ready);
            emiss = erv && !p2hit[p];
            epa   = (erv && p2hit[p]) ? p2pa[p] : '0;
            ewv   = p2v[p] && !p2hit[p];
            evpn  = ewv ? p2vpn[p] : '0;
            check(resp_valid[p] == erv && resp_miss[p] == emiss && walk_valid[p] == ewv,
                  "R12 model flags", {resp_valid[p], resp_miss[p], walk_valid[p]},
                  {erv, emiss, ewv});
            check(resp_paddr[p*PA_W +: PA_W] == epa && walk_vpn[p*VPN_W +: VPN_W] == evpn,
                  "R13 model data", resp_paddr[p*PA_W +: PA_W], epa);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #5;
        if (started && !rst) model_compare();
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input int p, input logic [VPN_W-1:0] vpn, input logic [11:0] off);
        req_valid[p] = 1'b1;
        req_vaddr[p*VA_W +: VA_W] = {vpn, off};
        tick();
        req_valid[p] = 1'b0;
        tick();
    endtask

    task automatic do_fill(input logic [TAG_W-1:0] tag, input logic [1:0] st,
                           input logic [HI_W-1:0] hi, input logic [23:0] lo,
                           input logic [7:0] sv, input bit strobe);
        fill_tag = tag; fill_stage = st; fill_asid = 16'h1234;
        fill_ppn_hi = hi; fill_ppn_lo = lo; fill_sec_valid = sv;
        fill_valid = strobe;
        tick();
        fill_valid = 1'b0;
    endtask

    function automatic logic [23:0] lo_pat(input int seed);
        logic [23:0] r;
        for (int i = 0; i < 8; i++) r[i*3 +: 3] = 3'((seed + i) % 8);
        return r;
    endfunction

    function automatic logic [TAG_W-1:0] tn(input int k);
        return 35'h0_5000_0000 + 35'(k);
    endfunction

    localparam logic [TAG_W-1:0] TAG_A = 35'h0_1234_5678;
    localparam logic [TAG_W-1:0] TAG_G = 35'h0_0777_0001;
    localparam logic [HI_W-1:0]  HI_A  = 33'h0_ABCD_1234;

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check(resp_valid == 0 && walk_valid == 0, "R1 quiet after reset",
              {resp_valid, walk_valid}, 0);

        // R5: miss on empty table
        lookup(0, {TAG_A, 3'd5}, 12'h111);
        check(resp_valid[0] && resp_miss[0] && walk_valid[0], "R5 miss flags",
              {resp_valid[0], resp_miss[0], walk_valid[0]}, 3'b111);
        check(walk_vpn[0 +: VPN_W] == {TAG_A, 3'd5}, "R5 walk vpn",
              walk_vpn[0 +: VPN_W], {TAG_A, 3'd5});

        // R2: response not there after one edge
        req_valid[1] = 1'b1;
        req_vaddr[VA_W +: VA_W] = {TAG_A, 3'd5, 12'h222};
        tick();
        req_valid[1] = 1'b0;
        check(!resp_valid[1], "R2 not after one edge", resp_valid[1], 0);
        tick();
        check(resp_valid[1], "R2 present after two edges", resp_valid[1], 1);
        tick();
        check(!resp_valid[1], "R2 single cycle", resp_valid[1], 0);

        // R6: fill data without strobe
        do_fill(TAG_A, 2'b00, HI_A, lo_pat(1), 8'hEF, 1'b0);
        lookup(0, {TAG_A, 3'd5}, 12'hABC);
        check(resp_miss[0], "R6 no strobe no fill", resp_miss[0], 1);

        // R3: real fill then hit (slot 0)
        do_fill(TAG_A, 2'b00, HI_A, lo_pat(1), 8'hEF, 1'b1);
        lookup(0, {TAG_A, 3'd5}, 12'hABC);
        check(resp_valid[0] && !resp_miss[0], "R3 hit", resp_miss[0], 0);
        check(resp_paddr[0 +: PA_W] == {HI_A, 3'd6, 12'hABC}, "R3 paddr",
              resp_paddr[0 +: PA_W], {HI_A, 3'd6, 12'hABC});

        // R4: sector 4 invalid
        lookup(1, {TAG_A, 3'd4}, 12'h001);
        check(resp_miss[1], "R4 sector invalid", resp_miss[1], 1);

        // R3: other asid
        cur_asid = 16'h5555;
        lookup(0, {TAG_A, 3'd5}, 12'h001);
        check(resp_miss[0], "R3 asid mismatch", resp_miss[0], 1);
        cur_asid = 16'h1234;

        // R7: guest entry (slot 1)
        do_fill(TAG_G, 2'b01, 33'h1_0000_0042, lo_pat(3), 8'hFF, 1'b1);
        lookup(0, {TAG_G, 3'd0}, 12'h010);
        check(resp_miss[0], "R7 guest entry vs stage 00", resp_miss[0], 1);
        cur_stage = 2'b11;
        lookup(0, {TAG_G, 3'd0}, 12'h010);
        check(!resp_miss[0] && resp_paddr[0 +: PA_W] == {33'h1_0000_0042, 3'd3, 12'h010},
              "R7 guest hit", resp_paddr[0 +: PA_W], {33'h1_0000_0042, 3'd3, 12'h010});
        lookup(1, {TAG_A, 3'd5}, 12'h010);
        check(resp_miss[1], "R7 plain entry vs guest stage", resp_miss[1], 1);
        cur_stage = 2'b00;

        // R11: port 2 ready gating
        resp2_ready = 1'b0;
        lookup(2, {TAG_A, 3'd5}, 12'h333);
        check(!resp_valid[2], "R11 held while not ready", resp_valid[2], 0);
        resp2_ready = 1'b1;
        #1;
        check(resp_valid[2] && resp_paddr[2*PA_W +: PA_W] == {HI_A, 3'd6, 12'h333},
              "R11 delivered when ready", resp_paddr[2*PA_W +: PA_W], {HI_A, 3'd6, 12'h333});

        // R10: flush drops in-flight request and same-edge request
        req_valid[1] = 1'b1;
        req_vaddr[VA_W +: VA_W] = {TAG_A, 3'd5, 12'h444};
        tick();
        flush[1] = 1'b1;
        tick();
        flush[1] = 1'b0;
        req_valid[1] = 1'b0;
        check(!resp_valid[1] && !walk_valid[1], "R10 flush drop",
              {resp_valid[1], walk_valid[1]}, 0);
        tick();
        check(!resp_valid[1] && !walk_valid[1], "R10 flush drop same-edge request",
              {resp_valid[1], walk_valid[1]}, 0);

        // R8: eight new tags evict A (slot 0) and G (slot 1)
        for (int k = 0; k < 8; k++) do_fill(tn(k), 2'b00, 33'(k + 16), lo_pat(k), 8'hFF, 1'b1);
        lookup(0, {TAG_A, 3'd5}, 12'h000);
        check(resp_miss[0], "R8 oldest evicted", resp_miss[0], 1);
        lookup(0, {tn(0), 3'd2}, 12'h000);
        check(!resp_miss[0], "R8 new tag resident", resp_miss[0], 0);

        // R9: overwrite tn(3) in place, pointer stays at slot 2 (tn(0))
        do_fill(tn(3), 2'b00, 33'h1_5555_0000, lo_pat(0), 8'hFF, 1'b1);
        lookup(1, {tn(3), 3'd7}, 12'h0F0);
        check(resp_paddr[PA_W +: PA_W] == {33'h1_5555_0000, 3'd7, 12'h0F0}, "R9 overwrite data",
              resp_paddr[PA_W +: PA_W], {33'h1_5555_0000, 3'd7, 12'h0F0});
        do_fill(tn(8), 2'b00, 33'h99, lo_pat(2), 8'hFF, 1'b1);
        lookup(0, {tn(0), 3'd1}, 12'h000);
        check(resp_miss[0], "R9 pointer not advanced (slot 2 evicted)", resp_miss[0], 1);
        lookup(0, {tn(1), 3'd1}, 12'h000);
        check(!resp_miss[0], "R9 next slot kept", resp_miss[0], 0);

        // R12: random concurrent traffic against the model
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < NP; p++) begin
                req_valid[p] = ($urandom % 10) < 6;
                req_vaddr[p*VA_W +: VA_W] = {tn($urandom % 6), 3'($urandom), 12'($urandom)};
            end
            flush = 3'(($urandom % 100) < 9 ? (1 << ($urandom % 3)) : 0);
            resp2_ready = ($urandom % 4) != 0;
            cur_asid = (($urandom % 5) == 0) ? 16'h0777 : 16'h1234;
            cur_stage = (($urandom % 8) == 0) ? 2'b10 : 2'b00;
            fill_valid = ($urandom % 4) == 0;
            fill_tag = tn($urandom % 6);
            fill_asid = (($urandom % 3) == 0) ? 16'h0777 : 16'h1234;
            fill_stage = (($urandom % 4) == 0) ? 2'b01 : 2'b00;
            fill_ppn_hi = {1'b0, $urandom};
            fill_ppn_lo = 24'($urandom);
            fill_sec_valid = 8'($urandom);
            @(negedge clk);
        end
        req_valid = '0;
        fill_valid = 1'b0;
        flush = '0;
        repeat (3) tick();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule